// File: doc/BRIEF.md
# Burst-Mode CDR Lock-Mode Sequencer

This block steers the two-bit lock-mode control of a clock-data recovery loop in a burst-mode optical receiver. It runs on the recovered parallel-word clock. Between bursts it keeps the loop tied to the local reference clock. When a burst starts it switches to a high-gain mode so that the loop acquires phase quickly. A delimiter is then searched for in the recovered words. Once that delimiter is seen, the block moves to the low-jitter normal tracking mode and stays there until the burst ends.

The delimiter search uses a sliding window made of two consecutive recovered words. At every bit offset, a masked comparison against a programmable pattern counts the mismatched bits. A match is declared when that count is at or below a programmable error threshold.

A programmable word budget limits acquisition: a burst whose delimiter never appears is dropped, and a failure pulse is raised. A static enable selects burst operation. While the enable is low the loop is held in normal mode. While it is high, equalizer auto-calibration is blocked.

Top module: `cdr_lockmode_seq`

## Requirements
- R1: `lock_mode` is `2'b10` (reference) when `seq_state` is 0 (idle), `2'b01` (high gain) when it is 1 (acquire), and `2'b11` (normal) when it is 2 (payload). The value `2'b00` never appears on `lock_mode` after the first clock edge, including while reset is held. `lock_mode` and `seq_state` change together on one clock edge.
- R2: In idle with the block enabled, a high `burst_start` or a low-to-high change of `sig_det` seen at a clock edge moves the block to acquire at that edge.
- R3: In acquire, the block moves to payload and pulses `delim_found` high for exactly one cycle, at the edge where a match is found. A match exists when, for some offset k in 0..W-1, bits [k+W-1:k] of the window {previous word, current `rx_word`} (previous word in the upper half) differ from `delim_pattern` in at most `delim_thresh` of the bit positions where `delim_mask` is 1.
- R4: Payload is held whatever data arrives, including further delimiter matches, and no further `delim_found` pulse is produced.
- R5: `burst_end` high, or a high-to-low change of `sig_det`, returns the block to idle from any state at that edge. This takes priority over a delimiter match in the same cycle.
- R6: If no match is found during the first `acq_timeout` words in acquire, the block returns to idle and pulses `acq_fail` for one cycle.
- R7: With `burst_en` low, `lock_mode` is `2'b11` and `seq_state` is 0 from the next edge on. This holds also in reset, and start requests are ignored.
- R8: `eq_cal_block` equals `burst_en`.
- R9: Synchronous reset gives idle, no pulses, and `lock_mode` of `2'b10` (or `2'b11` while `burst_en` is low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered parallel-word clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_en | input | 1 | Static burst-operation enable |
| sig_det | input | 1 | Signal-detect level from the optics |
| burst_start | input | 1 | Burst-start strobe |
| burst_end | input | 1 | Burst-end strobe |
| rx_word | input | W | Recovered parallel data word |
| delim_pattern | input | W | Delimiter pattern |
| delim_mask | input | W | Per-bit compare enable for the delimiter |
| delim_thresh | input | clog2(W+1) | Allowed mismatched bits |
| acq_timeout | input | TO_W | Acquisition budget in words |
| lock_mode | output | 2 | Registered CDR lock-mode control |
| eq_cal_block | output | 1 | Equalizer auto-calibration inhibit |
| delim_found | output | 1 | One-cycle delimiter-found pulse |
| acq_fail | output | 1 | One-cycle acquisition-timeout pulse |
| seq_state | output | 2 | Sequencer state: 0 idle, 1 acquire, 2 payload |

## Verification
The bench builds the block with W=8 and TO_W=6. The 16-bit window then has only eight offsets, so a delimiter split across two words is easy to place by hand, and single-bit threshold and nibble-mask cases can be written out directly. A short budget of five words lets the timeout edge be hit exactly, and an abort can be placed in the same cycle as a delimiter match. A scoreboard queue holds the expected found and fail pulses in order, each with the lock mode that must come with it.

// File: rtl/cdr_seq_pkg.sv
package cdr_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_PAY  = 2'd2
  } seq_state_e;

  localparam logic [1:0] LM_HIGH_GAIN = 2'b01;
  localparam logic [1:0] LM_REF       = 2'b10;
  localparam logic [1:0] LM_NORMAL    = 2'b11;

  function automatic logic [1:0] mode_of(seq_state_e s);
    case (s)
      ST_ACQ:  return LM_HIGH_GAIN;
      ST_PAY:  return LM_NORMAL;
      default: return LM_REF;
    endcase
  endfunction

endpackage

// File: rtl/cdr_delim_match.sv
module cdr_delim_match #(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [W-1:0]           rx_word,
  input  logic [W-1:0]           pattern,
  input  logic [W-1:0]           mask,
  input  logic [$clog2(W+1)-1:0] thresh,
  output logic                   hit
);
  localparam int CNT_W = $clog2(W+1);
  localparam int WIN_W = 2 * W;

  logic [W-1:0]     prev_q;
  logic [WIN_W-1:0] window;
  logic [W-1:0]     off_hit;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= rx_word;
  end

  assign window = {prev_q, rx_word};

  for (genvar k = 0; k < W; k++) begin : g_off
    logic [W-1:0]     diff;
    logic [CNT_W-1:0] errs;
    assign diff = (window[k +: W] ^ pattern) & mask;
    always_comb begin
      errs = '0;
      for (int b = 0; b < W; b++) errs = errs + CNT_W'(diff[b]);
    end
    assign off_hit[k] = (errs <= thresh);
  end

  assign hit = |off_hit;

endmodule

// File: rtl/cdr_acq_timer.sv
module cdr_acq_timer #(
  parameter int TO_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            last
);
  logic [TO_W-1:0] cnt_q;

  assign last = ({1'b0, cnt_q} + (TO_W+1)'(1)) >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (!last)  cnt_q <= cnt_q + 1'b1;
  end

  // R6: while running the count never passes the budget
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (run && limit != '0) |-> (cnt_q < limit));

endmodule

// File: rtl/cdr_lockmode_seq.sv
module cdr_lockmode_seq
  import cdr_seq_pkg::*;
#(
  parameter int W    = 16,
  parameter int TO_W = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   burst_en,
  input  logic                   sig_det,
  input  logic                   burst_start,
  input  logic                   burst_end,
  input  logic [W-1:0]           rx_word,
  input  logic [W-1:0]           delim_pattern,
  input  logic [W-1:0]           delim_mask,
  input  logic [$clog2(W+1)-1:0] delim_thresh,
  input  logic [TO_W-1:0]        acq_timeout,
  output logic [1:0]             lock_mode,
  output logic                   eq_cal_block,
  output logic                   delim_found,
  output logic                   acq_fail,
  output logic [1:0]             seq_state
);
  seq_state_e state_q, state_n;
  logic [1:0] mode_q;
  logic       sd_q, found_q, fail_q, found_n, fail_n;
  logic       hit, tmo_last, start, abort;

  cdr_delim_match #(.W(W)) u_match (
    .clk(clk), .rst(rst), .rx_word(rx_word), .pattern(delim_pattern),
    .mask(delim_mask), .thresh(delim_thresh), .hit(hit)
  );

  cdr_acq_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst(rst), .run(state_q == ST_ACQ),
    .limit(acq_timeout), .last(tmo_last)
  );

  assign start = burst_start | (sig_det & ~sd_q);
  assign abort = burst_end | (~sig_det & sd_q);

  always_comb begin
    state_n = state_q;
    found_n = 1'b0;
    fail_n  = 1'b0;
    if (!burst_en || abort) begin
      state_n = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start) state_n = ST_ACQ;
        ST_ACQ: begin
          if (hit) begin
            state_n = ST_PAY;
            found_n = 1'b1;
          end else if (tmo_last) begin
            state_n = ST_IDLE;
            fail_n  = 1'b1;
          end
        end
        ST_PAY:  state_n = ST_PAY;
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= burst_en ? LM_REF : LM_NORMAL;
      sd_q    <= 1'b0;
      found_q <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      mode_q  <= burst_en ? mode_of(state_n) : LM_NORMAL;
      sd_q    <= sig_det;
      found_q <= found_n;
      fail_q  <= fail_n;
    end
  end

  assign lock_mode    = mode_q;
  assign seq_state    = state_q;
  assign delim_found  = found_q;
  assign acq_fail     = fail_q;
  assign eq_cal_block = burst_en;

  // R1: reserved code never driven once a clock edge has passed
  a_r1_no_reserved: assert property (@(posedge clk)
    $past(1'b1) |-> (mode_q != 2'b00));

  // R1: acquire runs in high gain, payload in normal tracking
  a_r1_acq_gain: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACQ) |-> (mode_q == LM_HIGH_GAIN));
  a_r1_pay_normal: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PAY) |-> (mode_q == LM_NORMAL));

  // R3: delimiter pulse lasts one cycle and lands in payload
  a_r3_found_pulse: assert property (@(posedge clk) disable iff (rst)
    delim_found |=> !delim_found);
  a_r3_found_pay: assert property (@(posedge clk) disable iff (rst)
    delim_found |-> (state_q == ST_PAY));

  // R5: burst end always returns to idle
  a_r5_end_idle: assert property (@(posedge clk) disable iff (rst)
    burst_end |=> (state_q == ST_IDLE));

  // R6: timeout pulse comes only out of acquire and lands in idle
  a_r6_fail_idle: assert property (@(posedge clk) disable iff (rst)
    acq_fail |-> (state_q == ST_IDLE && $past(state_q) == ST_ACQ));

  // R7: disabled operation pins normal mode and idle
  a_r7_disabled: assert property (@(posedge clk) disable iff (rst)
    !burst_en |=> (mode_q == LM_NORMAL && state_q == ST_IDLE));

endmodule

// File: tb/cdr_lockmode_seq_tb.sv
module cdr_lockmode_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int TO_W = 6;

  logic clk = 1'b0;
  logic rst, burst_en, sig_det, burst_start, burst_end;
  logic [W-1:0] rx_word, delim_pattern, delim_mask;
  logic [$clog2(W+1)-1:0] delim_thresh;
  logic [TO_W-1:0] acq_timeout;
  logic [1:0] lock_mode, seq_state;
  logic eq_cal_block, delim_found, acq_fail;

  int checks = 0;
  int errors = 0;

  typedef struct packed { logic is_found; logic [1:0] mode; } ev_t;
  ev_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cdr_lockmode_seq #(.W(W), .TO_W(TO_W)) u_dut (
    .clk(clk), .rst(rst), .burst_en(burst_en), .sig_det(sig_det),
    .burst_start(burst_start), .burst_end(burst_end), .rx_word(rx_word),
    .delim_pattern(delim_pattern), .delim_mask(delim_mask),
    .delim_thresh(delim_thresh), .acq_timeout(acq_timeout),
    .lock_mode(lock_mode), .eq_cal_block(eq_cal_block),
    .delim_found(delim_found), .acq_fail(acq_fail), .seq_state(seq_state)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_ev(logic is_found, logic [1:0] mode);
    ev_t e;
    e.is_found = is_found;
    e.mode = mode;
    exp_q.push_back(e);
  endtask

  task automatic chk_st(string req, logic [1:0] st, logic [1:0] md);
    chk(req, "seq_state", 8'(seq_state), 8'(st));
    chk(req, "lock_mode", 8'(lock_mode), 8'(md));
  endtask

  // scoreboard monitor: pulses must match the queued expectations in order
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (lock_mode == 2'b00) begin
        errors++;
        $display("FAIL R1 lock_mode: actual 0 expected nonzero");
      end
      if (delim_found || acq_fail) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R3/R6 pulse: actual found=%0b fail=%0b expected none",
                   delim_found, acq_fail);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          if (e.is_found !== delim_found || e.mode !== lock_mode) begin
            errors++;
            $display("FAIL R3/R6 event: actual found=%0b mode=%0h expected found=%0b mode=%0h",
                     delim_found, lock_mode, e.is_found, e.mode);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; burst_en = 1; sig_det = 0; burst_start = 0; burst_end = 0;
    rx_word = 8'h00; delim_pattern = 8'hA5; delim_mask = 8'hFF;
    delim_thresh = 0; acq_timeout = 20;
    tick(); tick();
    // R9 reset state
    chk_st("R9", 2'd0, 2'b10);
    chk("R9", "delim_found", 8'(delim_found), 8'h0);
    chk("R9", "acq_fail", 8'(acq_fail), 8'h0);
    chk("R8", "eq_cal_block", 8'(eq_cal_block), 8'h1);
    rst = 0; tick();

    // R2 burst start, R3 aligned delimiter, R4 payload hold, R5 end
    burst_start = 1; tick(); burst_start = 0;
    chk_st("R2", 2'd1, 2'b01);
    tick(); tick(); tick();
    chk_st("R6", 2'd1, 2'b01);
    rx_word = 8'hA5; expect_ev(1'b1, 2'b11); tick();
    chk_st("R3", 2'd2, 2'b11);
    chk("R3", "delim_found", 8'(delim_found), 8'h1);
    tick();
    chk("R4", "delim_found", 8'(delim_found), 8'h0);
    rx_word = 8'h5A; tick(); rx_word = 8'h00; tick(); tick();
    chk_st("R4", 2'd2, 2'b11);
    burst_end = 1; tick(); burst_end = 0;
    chk_st("R5", 2'd0, 2'b10);

    // R6 timeout after five words
    acq_timeout = 5;
    burst_start = 1; tick(); burst_start = 0;
    tick(); tick(); tick(); tick();
    chk_st("R6", 2'd1, 2'b01);
    expect_ev(1'b0, 2'b10); tick();
    chk_st("R6", 2'd0, 2'b10);
    chk("R6", "acq_fail", 8'(acq_fail), 8'h1);
    tick();
    chk("R6", "acq_fail", 8'(acq_fail), 8'h0);
    acq_timeout = 20;

    // R3 delimiter straddling two words (offset 4)
    burst_start = 1; tick(); burst_start = 0;
    rx_word = 8'h0A; tick();
    rx_word = 8'h50; expect_ev(1'b1, 2'b11); tick();
    chk_st("R3", 2'd2, 2'b11);
    rx_word = 8'h00; burst_end = 1; tick(); burst_end = 0;

    // R3 threshold: one bit off rejected at 0, accepted at 1
    burst_start = 1; tick(); burst_start = 0;
    rx_word = 8'hA4; tick(); rx_word = 8'h00; tick(); tick(); tick();
    chk_st("R3", 2'd1, 2'b01);
    burst_end = 1; tick(); burst_end = 0;
    delim_thresh = 1;
    burst_start = 1; tick(); burst_start = 0;
    rx_word = 8'hA4; expect_ev(1'b1, 2'b11); tick();
    chk_st("R3", 2'd2, 2'b11);
    rx_word = 8'h00; burst_end = 1; tick(); burst_end = 0;
    delim_thresh = 0;

    // R3 mask: low nibble ignored
    delim_mask = 8'hF0;
    burst_start = 1; tick(); burst_start = 0;
    rx_word = 8'hAF; expect_ev(1'b1, 2'b11); tick();
    chk_st("R3", 2'd2, 2'b11);
    rx_word = 8'h00; burst_end = 1; tick(); burst_end = 0;
    delim_mask = 8'hFF;

    // R2 / R5 signal-detect edges
    sig_det = 1; tick();
    chk_st("R2", 2'd1, 2'b01);
    tick();
    chk_st("R2", 2'd1, 2'b01);
    sig_det = 0; tick();
    chk_st("R5", 2'd0, 2'b10);

    // R5 abort wins over a same-cycle match
    burst_start = 1; tick(); burst_start = 0;
    rx_word = 8'hA5; burst_end = 1; tick(); burst_end = 0;
    chk_st("R5", 2'd0, 2'b10);
    chk("R5", "delim_found", 8'(delim_found), 8'h0);
    rx_word = 8'h00; tick();

    // R7 / R8 disabled operation
    burst_en = 0; #1;
    chk("R8", "eq_cal_block", 8'(eq_cal_block), 8'h0);
    tick();
    chk_st("R7", 2'd0, 2'b11);
    burst_start = 1; tick(); burst_start = 0;
    chk_st("R7", 2'd0, 2'b11);
    sig_det = 1; tick();
    chk_st("R7", 2'd0, 2'b11);
    sig_det = 0; rst = 1; tick();
    chk_st("R9", 2'd0, 2'b11);
    burst_en = 1; tick(); rst = 0;
    chk_st("R9", 2'd0, 2'b10);
    chk("R8", "eq_cal_block", 8'(eq_cal_block), 8'h1);
    tick(); tick();

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3/R6 pending events: actual %0d expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule